// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

The arbiter watches a bank of 81 interrupt request lines, indexed 0 to 80. Each line has an enable bit and a level bit that puts it in the high or the low class. Every cycle the block picks one winner and presents it to the processor core as a registered vector number with a valid flag and the winning level. The user-assigned level is compared first. When several lines in the same level are pending, the one with the smaller index wins.

The core acknowledges a presented vector to mark it as in service. It pulses a return input when a handler finishes. A high-level request may interrupt a low-level handler. While a high-level handler runs, nothing new is presented. With vectored mode off, the block only signals that something is pending and reports vector 0.

Top module: `vic_arbiter`

## Requirements
- R1: A line whose enable bit is 0, or whose index is one of the unused slots 63 (0x3F) and 80 (0x50), never becomes the presented vector and never raises `irq_valid`.
- R2: When enabled requests exist in both levels, the winner is a high-level line (`irq_level` = 1), whatever its index. Low level is encoded as `irq_level` = 0.
- R3: Among pending enabled requests of the winning level, the smallest index is presented on `irq_vec`.
- R4: `irq_valid`, `irq_vec`, `irq_level`, `pend_hi` and `pend_lo` are registered. They reflect the inputs present before the clock edge one cycle after those inputs change.
- R5: While `irq_valid` is 1 and `ack` is 0, the vector and level hold steady, even if a stronger request arrives. An edge with `ack` = 1 drops `irq_valid` for at least one cycle and marks the presented level as in service.
- R6: While a low-level handler is in service, low-level requests are not presented. An enabled high-level request is presented (preemption).
- R7: While a high-level handler is in service, no vector is presented until `reti` is pulsed.
- R8: A `reti` pulse clears only the highest level that is in service. After a nested high-level handler returns, the low level stays in service until a second `reti`.
- R9: With `vec_mode` = 0, `irq_vec` reads 0 whenever a request is presented. `pend_hi` and `pend_lo` report whether any enabled, used request of each level is pending.
- R10: Synchronous reset clears both in-service flags and deasserts `irq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 1 = vectored arbitration, 0 = pending flags only |
| req | input | 81 | Raw request lines, bit n = vector n |
| en | input | 81 | Per-line enable |
| lvl_hi | input | 81 | Per-line level: 1 = high, 0 = low |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Handler return pulse |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 7 | Presented vector number |
| irq_level | output | 1 | Level of the presented vector |
| pend_hi | output | 1 | Some enabled high-level request pending |
| pend_lo | output | 1 | Some enabled low-level request pending |

## Verification
The hardest state to reach is a high-level handler nested inside a low-level one, followed by the two returns unwinding it. In that state the low requests must stay blocked after the first return. The bench reaches it through the ports alone. It presents and acknowledges a low line, then raises and acknowledges a high line. It pulses `reti` while still holding low requests, so that only a correct unwinding keeps them hidden until the second pulse. Index sweeps over every single line and over many line pairs in both level mixes cover the masking and ordering rules.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int IRQ_NUM = 81;
    localparam int IRQ_VW  = $clog2(IRQ_NUM);
    localparam logic [IRQ_NUM-1:0] IRQ_UNUSED =
        (IRQ_NUM'(1) << 63) | (IRQ_NUM'(1) << 80);

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } irq_lvl_e;

    typedef struct packed {
        logic              valid;
        logic [IRQ_VW-1:0] vec;
        irq_lvl_e          level;
    } irq_sel_t;
endpackage

// File: rtl/vic_first_set.sv
module vic_first_set #(
    parameter int WIDTH = 81,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             any_set,
    output logic [IDX_W-1:0] first_idx
);
    always_comb begin
        first_idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits_in[i]) begin
                first_idx = IDX_W'(i);
            end
        end
    end

    assign any_set = |bits_in;
endmodule

// File: rtl/vic_service_track.sv
module vic_service_track (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output logic svc_hi,
    output logic svc_lo
);
    logic hi_next, lo_next;

    always_comb begin
        hi_next = svc_hi;
        lo_next = svc_lo;
        if (reti) begin
            if (svc_hi) hi_next = 1'b0;
            else        lo_next = 1'b0;
        end
        if (take) begin
            if (take_hi) hi_next = 1'b1;
            else         lo_next = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            svc_hi <= hi_next;
            svc_lo <= lo_next;
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int                 NUM_VEC = IRQ_NUM,
    parameter logic [NUM_VEC-1:0] UNUSED  = IRQ_UNUSED
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vec_mode,
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] en,
    input  logic [NUM_VEC-1:0] lvl_hi,
    input  logic               ack,
    input  logic               reti,
    output logic               irq_valid,
    output logic [IRQ_VW-1:0]  irq_vec,
    output logic               irq_level,
    output logic               pend_hi,
    output logic               pend_lo
);
    logic [NUM_VEC-1:0] live, hi_bits, lo_bits;
    logic               hi_any, lo_any;
    logic [IRQ_VW-1:0]  hi_idx, lo_idx;
    logic               svc_hi, svc_lo;
    irq_sel_t           cand, sel_q;
    logic               taken;

    assign live    = req & en & ~UNUSED;
    assign hi_bits = live & lvl_hi;
    assign lo_bits = live & ~lvl_hi;

    vic_first_set #(.WIDTH(NUM_VEC), .IDX_W(IRQ_VW)) hi_enc_i (
        .bits_in(hi_bits), .any_set(hi_any), .first_idx(hi_idx)
    );
    vic_first_set #(.WIDTH(NUM_VEC), .IDX_W(IRQ_VW)) lo_enc_i (
        .bits_in(lo_bits), .any_set(lo_any), .first_idx(lo_idx)
    );

    assign taken = sel_q.valid & ack;

    vic_service_track track_i (
        .clk    (clk),
        .rst    (rst),
        .take   (taken),
        .take_hi(sel_q.level == LVL_HI),
        .reti   (reti),
        .svc_hi (svc_hi),
        .svc_lo (svc_lo)
    );

    always_comb begin
        cand = '{valid: 1'b0, vec: '0, level: LVL_LO};
        if (!svc_hi) begin
            if (hi_any) begin
                cand = '{valid: 1'b1, vec: hi_idx, level: LVL_HI};
            end else if (lo_any && !svc_lo) begin
                cand = '{valid: 1'b1, vec: lo_idx, level: LVL_LO};
            end
        end
        if (!vec_mode) begin
            cand.vec = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '{valid: 1'b0, vec: '0, level: LVL_LO};
            pend_hi <= 1'b0;
            pend_lo <= 1'b0;
        end else begin
            pend_hi <= hi_any;
            pend_lo <= lo_any;
            if (sel_q.valid) begin
                if (ack) sel_q.valid <= 1'b0;
            end else begin
                sel_q <= cand;
            end
        end
    end

    assign irq_valid = sel_q.valid;
    assign irq_vec   = sel_q.vec;
    assign irq_level = sel_q.level;
endmodule

// File: rtl/vic_arbiter_chk.sv
module vic_arbiter_chk
    import vic_pkg::*;
#(
    parameter int                 NUM_VEC = IRQ_NUM,
    parameter logic [NUM_VEC-1:0] UNUSED  = IRQ_UNUSED
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic              irq_valid,
    input logic [IRQ_VW-1:0] irq_vec,
    input logic              irq_level
);
    localparam int PADW = 2 ** IRQ_VW;
    localparam logic [PADW-1:0] HOLES = PADW'(UNUSED) | ~((PADW'(1) << NUM_VEC) - PADW'(1));

    // R1
    no_unused_vec_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !HOLES[irq_vec]);

    // R5
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid && !ack |=> irq_valid && $stable(irq_vec) && $stable(irq_level));

    // R5
    ack_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid && ack |=> !irq_valid);

    // R10
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_valid);
endmodule

bind vic_arbiter vic_arbiter_chk #(.NUM_VEC(NUM_VEC), .UNUSED(UNUSED)) chk_i (
    .clk(clk), .rst(rst), .ack(ack), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_level(irq_level)
);

// File: tb/vic_arbiter_tb_top.sv
`timescale 1ns/1ps
module vic_arbiter_tb_top;
    localparam int N = 81;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vec_mode = 1'b1;
    logic [N-1:0] req = '0, en = '0, lvl_hi = '0;
    logic         ack = 1'b0, reti = 1'b0;
    logic         irq_valid, irq_level, pend_hi, pend_lo;
    logic [6:0]   irq_vec;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vic_arbiter dut_i (
        .clk(clk), .rst(rst), .vec_mode(vec_mode), .req(req), .en(en),
        .lvl_hi(lvl_hi), .ack(ack), .reti(reti), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_level(irq_level), .pend_hi(pend_hi),
        .pend_lo(pend_lo)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit used(input int i);
        return (i != 63) && (i != 80);
    endfunction

    task automatic do_reset();
        rst = 1'b1; req = '0; ack = 1'b0; reti = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    initial begin
        #900000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        en = '1;
        do_reset();
        // R10 reset state
        chk("R10 valid", irq_valid, 0);

        // R1 R3 R4: single line sweep, both levels, enabled and disabled
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 2; l++) begin
                do_reset();
                en = '1; lvl_hi = l ? '1 : '0;
                req = '0; req[i] = 1'b1;
                step();
                chk("R1 R4 single valid", irq_valid, used(i));
                if (used(i)) begin
                    chk("R3 single vec", irq_vec, i);
                    chk("R2 single level", irq_level, l);
                end
                do_reset();
                en = '1; en[i] = 1'b0;
                req = '0; req[i] = 1'b1;
                step();
                chk("R1 disabled", irq_valid, 0);
            end
        end
        en = '1;

        // R2 R3: pair sweep
        for (int i = 0; i < N; i++) begin
            for (int k = 1; k < 4; k++) begin
                int j = (i * 37 + 11 * k) % N;
                int e;
                if (j == i) continue;
                // same level, both high
                do_reset();
                lvl_hi = '1; req = '0; req[i] = 1'b1; req[j] = 1'b1;
                step();
                e = -1;
                if (used(i)) e = i;
                if (used(j) && (e < 0 || j < e)) e = j;
                chk("R3 pair valid", irq_valid, e >= 0);
                if (e >= 0) chk("R3 pair vec", irq_vec, e);
                // i low, j high
                do_reset();
                lvl_hi = '0; lvl_hi[j] = 1'b1;
                req = '0; req[i] = 1'b1; req[j] = 1'b1;
                step();
                if (used(j)) begin
                    chk("R2 mix vec", irq_vec, j);
                    chk("R2 mix level", irq_level, 1);
                end else if (used(i)) begin
                    chk("R2 mix vec lo", irq_vec, i);
                    chk("R2 mix level lo", irq_level, 0);
                end else begin
                    chk("R1 mix none", irq_valid, 0);
                end
            end
        end

        // R5 hold until ack, then preemption
        do_reset();
        lvl_hi = '0; lvl_hi[0] = 1'b1;
        req = '0; req[5] = 1'b1;
        step();
        chk("R5 first vec", irq_vec, 5);
        req[0] = 1'b1;
        step();
        chk("R5 held vec", irq_vec, 5);
        chk("R5 held level", irq_level, 0);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R5 ack drop", irq_valid, 0);
        step();
        chk("R6 preempt vec", irq_vec, 0);
        chk("R6 preempt level", irq_level, 1);

        // R6 R7 R8 nesting and unwinding
        do_reset();
        lvl_hi = '0; lvl_hi[70] = 1'b1; lvl_hi[1] = 1'b1;
        req = '0; req[5] = 1'b1;
        step();
        chk("R6 low vec", irq_vec, 5);
        ack = 1'b1; step(); ack = 1'b0;
        chk("R5 ack drop lo", irq_valid, 0);
        req[2] = 1'b1;
        step(); step();
        chk("R6 low blocked", irq_valid, 0);
        req[70] = 1'b1;
        step();
        chk("R6 nest valid", irq_valid, 1);
        chk("R6 nest vec", irq_vec, 70);
        chk("R6 nest level", irq_level, 1);
        ack = 1'b1; step(); ack = 1'b0;
        req[1] = 1'b1;
        step(); step();
        chk("R7 high blocked", irq_valid, 0);
        reti = 1'b1; req[1] = 1'b0; req[70] = 1'b0;
        step(); reti = 1'b0;
        step(); step();
        chk("R8 low still in service", irq_valid, 0);
        reti = 1'b1; step(); reti = 1'b0;
        step();
        chk("R8 unwound valid", irq_valid, 1);
        chk("R8 unwound vec", irq_vec, 2);
        chk("R8 unwound level", irq_level, 0);

        // R9 non-vectored mode
        do_reset();
        vec_mode = 1'b0;
        lvl_hi = '0; lvl_hi[40] = 1'b1;
        req = '0; req[40] = 1'b1; req[3] = 1'b1;
        step();
        chk("R9 valid", irq_valid, 1);
        chk("R9 vec zero", irq_vec, 0);
        chk("R9 pend_hi", pend_hi, 1);
        chk("R9 pend_lo", pend_lo, 1);
        req[40] = 1'b0; req[63] = 1'b1; lvl_hi[63] = 1'b1;
        step();
        chk("R9 R1 pend_hi clear", pend_hi, 0);
        chk("R9 pend_lo kept", pend_lo, 1);
        vec_mode = 1'b1;

        // R10 reset in service
        rst = 1'b1; step(); rst = 1'b0;
        chk("R10 valid after reset", irq_valid, 0);
        req = '0; req[9] = 1'b1; lvl_hi = '0;
        step();
        chk("R10 service cleared", irq_vec, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule